// File: doc/BRIEF.md
# DRAM Refresh and Initialization Sequencer

This block sits on the controller side of an asynchronous DRAM. It owns the row strobe, both column strobes and the write strobe whenever the memory is not serving a host access. After reset it waits out the power-up pause. It then issues a burst of wake-up cycles and raises `init_done`. From then on it keeps the array alive with distributed refresh cycles in which CAS falls before RAS. In those cycles no row address is driven, because the memory's internal counter selects the row, and WE stays high.

The host access path reaches the memory through an arbiter. That arbiter talks to this block with a request, a one-cycle grant and a busy level that covers the access in progress. A refresh never starts while an access is in flight. Refreshes that come due during a long access are counted in a small backlog and run back to back once the bus is free. While the backlog is below its limit, a waiting host request wins over a due refresh. When the backlog is full, the refresh wins. If no refresh has completed for a full retention period, for example because a single access held the bus too long, the block drops `init_done` and repeats the wake-up burst without the long pause.

All timing limits are parameters in nanoseconds. They are converted to clock counts by rounding up, with a floor of one cycle.

Top module: `dram_refresh_seq`

## Requirements
- R1: In reset and in the first cycle after it, `ras_n`, `lcas_n`, `ucas_n` and `we_n` are 1, and `init_done` and `host_grant` are 0.
- R2: After reset is released, RAS does not fall for at least ceil(PWRUP_NS/CLK_NS) cycles, and it first falls no more than four cycles after that count.
- R3: After the pause, exactly WAKE_CYCLES refresh cycles are issued, and then `init_done` rises. `host_grant` is never 1 while `init_done` is 0, even with `host_req` held at 1.
- R4: Every RAS falling edge is a CAS-before-RAS edge with the following timing. Both CAS strobes are 0 and equal. CAS has been low for at least ceil(TCSR_NS/CLK_NS) cycles before RAS falls and stays low for at least ceil(TCHR_NS/CLK_NS) cycles after. RAS stays low for at least ceil(TRAS_NS/CLK_NS) cycles. RAS has been high for at least ceil(TRP_NS/CLK_NS) cycles before it falls.
- R5: `we_n` is 1 in every cycle.
- R6: With no host traffic, one refresh cycle is performed per ceil(REF_INT_NS/CLK_NS) cycles.
- R7: No refresh or wake-up cycle starts while `host_busy` is 1 or in the cycle of a grant. All strobes are 1 while `host_grant` or `host_busy` is 1.
- R8: Refreshes that come due during an access are counted, up to BACKLOG_MAX, and run back to back once the access ends. Over time, the number of refreshes matches the number of intervals elapsed.
- R9: While the backlog is below BACKLOG_MAX, a pending `host_req` is granted ahead of a due refresh. At BACKLOG_MAX, the refresh is started first. Under continuous host traffic, no refresh runs until the backlog is full.
- R10: `host_grant` is a one-cycle pulse. It is given within 12 cycles of a request in the bench setting.
- R11: If no refresh completes for ceil(REF_LIMIT_NS/CLK_NS) cycles, `init_done` falls once the access ends. WAKE_CYCLES refresh cycles then follow without the power-up pause, and `init_done` rises again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Host arbiter wants the memory |
| host_busy | input | 1 | A host access is in progress (raised after a grant) |
| host_grant | output | 1 | One-cycle pulse: host may start its access |
| init_done | output | 1 | Power-up and wake-up complete, normal access allowed |
| ras_n | output | 1 | Row strobe, active low |
| lcas_n | output | 1 | Lower-byte column strobe, active low |
| ucas_n | output | 1 | Upper-byte column strobe, active low |
| we_n | output | 1 | Write strobe, active low, held high |

## Verification
A due refresh and a waiting host request can be decided in the same cycle. The backlog level alone picks the winner: below the limit the host is granted, at the limit the refresh goes first. The bench provokes this tie with back-to-back host accesses in which `host_req` never drops. The decision then falls due again at the end of every access. The tie is judged by the refresh count at the pins: it must stay at zero for the first seven intervals and then rise at about one refresh per interval. The bench also has a long access that saturates the backlog and outlasts the retention limit. It judges the resulting re-wake by the fall of `init_done`, the count of eight wake-up cycles and the missing pause.

// File: rtl/dram_refresh_pkg.sv
package dram_refresh_pkg;

    typedef enum logic [1:0] {
        TOP_PAUSE,
        TOP_WAKE,
        TOP_IDLE,
        TOP_REFRESH
    } top_state_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_SETUP,
        SQ_LOW,
        SQ_PRE
    } seq_state_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
    } strobe_t;

    // ceiling conversion of a time limit to clock cycles, at least one
    function automatic int ns_to_cycles(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/cbr_strobe_seq.sv
module cbr_strobe_seq
    import dram_refresh_pkg::*;
#(
    parameter int N_CSR = 1,
    parameter int N_CHR = 1,
    parameter int N_RAS = 5,
    parameter int N_RP  = 3
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    output strobe_t strobe,
    output logic    busy,
    output logic    done
);
    localparam int N_LOW = max2(N_RAS, N_CHR);
    localparam int N_TOP = max2(max2(N_CSR, N_LOW), N_RP);
    localparam int CW    = $clog2(N_TOP + 1);

    seq_state_e    state, nxt;
    logic [CW-1:0] cnt, nxt_cnt;
    logic          fin;
    strobe_t       nxt_strobe;

    always_comb begin
        nxt     = state;
        nxt_cnt = cnt + CW'(1);
        fin     = 1'b0;
        case (state)
            SQ_IDLE: begin
                nxt_cnt = '0;
                if (start) nxt = SQ_SETUP;
            end
            SQ_SETUP: if (cnt == CW'(N_CSR - 1)) begin
                nxt     = SQ_LOW;
                nxt_cnt = '0;
            end
            SQ_LOW: if (cnt == CW'(N_LOW - 1)) begin
                nxt     = SQ_PRE;
                nxt_cnt = '0;
            end
            SQ_PRE: if (cnt == CW'(N_RP - 1)) begin
                nxt     = SQ_IDLE;
                nxt_cnt = '0;
                fin     = 1'b1;
            end
            default: nxt = SQ_IDLE;
        endcase
        nxt_strobe.ras_n = (nxt != SQ_LOW);
        nxt_strobe.cas_n = !((nxt == SQ_SETUP) ||
                             ((nxt == SQ_LOW) && (nxt_cnt < CW'(N_CHR))));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SQ_IDLE;
            cnt    <= '0;
            strobe <= '1;
            done   <= 1'b0;
        end else begin
            state  <= nxt;
            cnt    <= nxt_cnt;
            strobe <= nxt_strobe;
            done   <= fin;
        end
    end

    assign busy = (state != SQ_IDLE);

    // R4
    cas_before_ras_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(strobe.ras_n) |-> !strobe.cas_n);

endmodule

// File: rtl/refresh_pacer.sv
module refresh_pacer
    import dram_refresh_pkg::*;
#(
    parameter int N_INT       = 40,
    parameter int N_LIMIT     = 600,
    parameter int BACKLOG_MAX = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic served,
    output logic pending,
    output logic urgent,
    output logic stale
);
    localparam int IW = $clog2(N_INT + 1);
    localparam int LW = $clog2(N_LIMIT + 1);
    localparam int BW = $clog2(BACKLOG_MAX + 2);

    logic [IW-1:0] int_cnt;
    logic [LW-1:0] stale_cnt;
    logic [BW-1:0] backlog;
    logic [BW:0]   sum;
    logic          tick;

    assign tick = run && (int_cnt == IW'(N_INT - 1));
    assign sum  = ({1'b0, backlog} + {{BW{1'b0}}, tick}) - {{BW{1'b0}}, served};

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            int_cnt   <= '0;
            backlog   <= '0;
            stale_cnt <= '0;
        end else begin
            int_cnt <= tick ? '0 : int_cnt + IW'(1);
            if (sum > (BW + 1)'(BACKLOG_MAX)) backlog <= BW'(BACKLOG_MAX);
            else                              backlog <= sum[BW-1:0];
            if (served)                             stale_cnt <= '0;
            else if (stale_cnt != LW'(N_LIMIT))     stale_cnt <= stale_cnt + LW'(1);
        end
    end

    assign pending = (backlog != '0);
    assign urgent  = (backlog == BW'(BACKLOG_MAX));
    assign stale   = (stale_cnt == LW'(N_LIMIT));

    // R8
    backlog_bound_chk: assert property (@(posedge clk) disable iff (rst)
        backlog <= BW'(BACKLOG_MAX));

    // R11
    stale_clear_chk: assert property (@(posedge clk) disable iff (rst)
        served |=> !stale);

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
    import dram_refresh_pkg::*;
#(
    parameter int CLK_NS       = 10,
    parameter int PWRUP_NS     = 200000,
    parameter int WAKE_CYCLES  = 8,
    parameter int REF_INT_NS   = 15625,
    parameter int REF_LIMIT_NS = 16000000,
    parameter int TCSR_NS      = 5,
    parameter int TCHR_NS      = 10,
    parameter int TRAS_NS      = 50,
    parameter int TRP_NS       = 30,
    parameter int BACKLOG_MAX  = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic host_req,
    input  logic host_busy,
    output logic host_grant,
    output logic init_done,
    output logic ras_n,
    output logic lcas_n,
    output logic ucas_n,
    output logic we_n
);
    localparam int N_PWR   = ns_to_cycles(PWRUP_NS, CLK_NS);
    localparam int N_INT   = ns_to_cycles(REF_INT_NS, CLK_NS);
    localparam int N_LIMIT = ns_to_cycles(REF_LIMIT_NS, CLK_NS);
    localparam int N_CSR   = ns_to_cycles(TCSR_NS, CLK_NS);
    localparam int N_CHR   = ns_to_cycles(TCHR_NS, CLK_NS);
    localparam int N_RAS   = ns_to_cycles(TRAS_NS, CLK_NS);
    localparam int N_RP    = ns_to_cycles(TRP_NS, CLK_NS);
    localparam int PW      = $clog2(N_PWR + 1);
    localparam int WW      = $clog2(WAKE_CYCLES + 1);

    top_state_e    state, nxt;
    logic [PW-1:0] pwr_cnt;
    logic [WW-1:0] wake_cnt;
    logic          grant_q, grant_d, init_q, init_d;
    logic          seq_start, seq_busy, seq_done, served;
    logic          pending, urgent, stale, blocked;
    strobe_t       strobe;

    cbr_strobe_seq #(
        .N_CSR(N_CSR), .N_CHR(N_CHR), .N_RAS(N_RAS), .N_RP(N_RP)
    ) i_seq (
        .clk(clk), .rst(rst), .start(seq_start),
        .strobe(strobe), .busy(seq_busy), .done(seq_done)
    );

    assign served = seq_done && (state == TOP_REFRESH);

    refresh_pacer #(
        .N_INT(N_INT), .N_LIMIT(N_LIMIT), .BACKLOG_MAX(BACKLOG_MAX)
    ) i_pacer (
        .clk(clk), .rst(rst), .run(init_q), .served(served),
        .pending(pending), .urgent(urgent), .stale(stale)
    );

    assign blocked = host_busy || grant_q;

    always_comb begin
        nxt       = state;
        seq_start = 1'b0;
        grant_d   = 1'b0;
        init_d    = init_q;
        case (state)
            TOP_PAUSE: if (pwr_cnt == PW'(N_PWR - 1)) nxt = TOP_WAKE;
            TOP_WAKE: begin
                if (seq_done && (wake_cnt == WW'(WAKE_CYCLES - 1))) begin
                    nxt    = TOP_IDLE;
                    init_d = 1'b1;
                end else if (!seq_busy) begin
                    seq_start = 1'b1;
                end
            end
            TOP_IDLE: begin
                if (blocked) begin
                    nxt = TOP_IDLE;
                end else if (stale) begin
                    nxt    = TOP_WAKE;
                    init_d = 1'b0;
                end else if (pending && (urgent || !host_req)) begin
                    nxt       = TOP_REFRESH;
                    seq_start = 1'b1;
                end else if (host_req) begin
                    grant_d = 1'b1;
                end
            end
            TOP_REFRESH: if (seq_done) nxt = TOP_IDLE;
            default: nxt = TOP_PAUSE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= TOP_PAUSE;
            pwr_cnt  <= '0;
            wake_cnt <= '0;
            grant_q  <= 1'b0;
            init_q   <= 1'b0;
        end else begin
            state   <= nxt;
            grant_q <= grant_d;
            init_q  <= init_d;
            if (state == TOP_PAUSE) pwr_cnt <= pwr_cnt + PW'(1);
            if (state != TOP_WAKE)  wake_cnt <= '0;
            else if (seq_done)      wake_cnt <= wake_cnt + WW'(1);
        end
    end

    assign host_grant = grant_q;
    assign init_done  = init_q;
    assign ras_n      = strobe.ras_n;
    assign lcas_n     = strobe.cas_n;
    assign ucas_n     = strobe.cas_n;
    assign we_n       = 1'b1;

    // R10
    grant_needs_init_chk: assert property (@(posedge clk) disable iff (rst)
        host_grant |-> init_done);

    // R10
    grant_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        host_grant |=> !host_grant);

    // R7
    grant_strobes_idle_chk: assert property (@(posedge clk) disable iff (rst)
        host_grant |-> (ras_n && lcas_n && ucas_n));

    // R7
    no_start_when_busy_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(lcas_n) |-> !$past(host_busy));

endmodule

// File: tb/test_dram_refresh_seq.sv
module test_dram_refresh_seq;

    localparam int CLK_PERIOD = 10;
    localparam int P_PWRUP    = 500;
    localparam int P_INT      = 400;
    localparam int P_LIMIT    = 6000;
    localparam int P_TCHR     = 20;
    localparam int WAKE_N     = 8;
    localparam int N_PWR      = (P_PWRUP + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int N_INT      = (P_INT + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int N_CSR      = 1;
    localparam int N_CHR      = (P_TCHR + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int N_RAS      = 5;
    localparam int N_RP       = 3;
    localparam int CBR_LEN    = N_CSR + N_RAS + N_RP;
    localparam int WD_LIMIT   = 20000;

    // stimulus rows: idle gap before request, busy length, max grant latency
    localparam int ROWS = 6;
    localparam int VEC [ROWS][3] = '{
        '{3, 4, 12}, '{0, 1, 12}, '{17, 6, 12},
        '{25, 2, 12}, '{9, 30, 12}, '{1, 15, 12}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic host_req = 1'b0;
    logic host_busy = 1'b0;
    logic host_grant, init_done, ras_n, lcas_n, ucas_n, we_n;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    int cyc = 0;
    bit prev_ras = 1'b1, prev_cas = 1'b1, prev_grant = 1'b0, prev_init = 1'b0;
    int cas_run = 0, ras_lo_run = 0, ras_hi_run = 100, cas_after = 0;
    int ref_cnt = 0, wake_seen = 0, first_fall = -1, t_init = 0;
    int r4_bad = 0, r5_bad = 0, r7_bad = 0, r10_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dram_refresh_seq #(
        .CLK_NS(CLK_PERIOD), .PWRUP_NS(P_PWRUP), .WAKE_CYCLES(WAKE_N),
        .REF_INT_NS(P_INT), .REF_LIMIT_NS(P_LIMIT), .TCSR_NS(5),
        .TCHR_NS(P_TCHR), .TRAS_NS(50), .TRP_NS(30), .BACKLOG_MAX(8)
    ) i_dram_refresh_seq (
        .clk(clk), .rst(rst), .host_req(host_req), .host_busy(host_busy),
        .host_grant(host_grant), .init_done(init_done), .ras_n(ras_n),
        .lcas_n(lcas_n), .ucas_n(ucas_n), .we_n(we_n)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // pin monitor, sampled at the falling clock edge
    always @(negedge clk) begin
        cyc++;
        if (rst) begin
            prev_ras = ras_n; prev_cas = lcas_n; prev_grant = 1'b0;
            prev_init = 1'b0; cas_run = 0; ras_lo_run = 0; ras_hi_run = 100;
        end else begin
            if (we_n !== 1'b1) r5_bad++;
            if (lcas_n !== ucas_n) r4_bad++;
            if ((host_grant || host_busy) && (!ras_n || !lcas_n)) r7_bad++;
            if (host_grant && !init_done) r10_bad++;
            if (host_grant && prev_grant) r10_bad++;
            if (prev_ras && !ras_n) begin
                if (lcas_n) r4_bad++;
                if (cas_run < N_CSR) r4_bad++;
                if (ras_hi_run < N_RP) r4_bad++;
                if (init_done) ref_cnt++; else wake_seen++;
                if (first_fall < 0) first_fall = cyc;
                cas_after = 0;
            end
            if (!prev_ras && ras_n && ras_lo_run < N_RAS) r4_bad++;
            if (!ras_n && !prev_cas && lcas_n && cas_after < N_CHR) r4_bad++;
            cas_run    = lcas_n ? 0 : cas_run + 1;
            ras_lo_run = ras_n ? 0 : ras_lo_run + 1;
            ras_hi_run = ras_n ? ras_hi_run + 1 : 0;
            if (!ras_n && !lcas_n) cas_after++;
            if (init_done && !prev_init) t_init = cyc;
            if (!init_done && prev_init) wake_seen = 0;
            prev_ras = ras_n; prev_cas = lcas_n;
            prev_grant = host_grant; prev_init = init_done;
        end
    end

    task automatic run_access(input int len, input bit keep_req, output int lat);
        host_req = 1'b1;
        lat = 0;
        while (host_grant !== 1'b1 && lat < 60) begin
            @(negedge clk);
            lat++;
        end
        host_busy = 1'b1;
        if (!keep_req) host_req = 1'b0;
        repeat (len) @(negedge clk);
        host_busy = 1'b0;
    endtask

    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1 run hung actual=%0d expected=%0d", cyc, WD_LIMIT);
            summary();
            $finish;
        end
    end

    initial begin
        int lat, rel, n, r0, t0, expv, t_fall;

        // R1 reset state, host requesting throughout initialization
        host_req = 1'b1;
        repeat (4) @(negedge clk);
        check(ras_n === 1'b1, "R1", "ras_n in reset", ras_n, 1);
        check(lcas_n === 1'b1 && ucas_n === 1'b1, "R1", "cas in reset", lcas_n, 1);
        check(init_done === 1'b0, "R1", "init_done in reset", init_done, 0);
        check(host_grant === 1'b0, "R1", "grant in reset", host_grant, 0);
        rst = 1'b0;
        #1 rel = cyc;
        @(negedge clk);
        check(ras_n === 1'b1 && lcas_n === 1'b1 && we_n === 1'b1, "R1",
              "strobes first cycle", {ras_n, lcas_n, we_n}, 7);

        // R2, R3 power-up pause and wake-up burst
        n = 0;
        while (!init_done && n < 600) begin @(negedge clk); n++; end
        #1;
        check(first_fall - rel >= N_PWR && first_fall - rel <= N_PWR + 4, "R2",
              "first RAS fall after release", first_fall - rel, N_PWR + 2);
        check(wake_seen == WAKE_N, "R3", "wake cycles before init_done", wake_seen, WAKE_N);
        check(r10_bad == 0, "R3", "grant before init_done", r10_bad, 0);
        host_req = 1'b0;
        repeat (3) @(negedge clk);

        // R6 idle refresh rate over twenty intervals
        #1 r0 = ref_cnt;
        repeat (20 * N_INT) @(negedge clk);
        #1;
        check(ref_cnt - r0 >= 19 && ref_cnt - r0 <= 21, "R6",
              "refreshes in 20 intervals", ref_cnt - r0, 20);

        // R10 table of host accesses
        for (int i = 0; i < ROWS; i++) begin
            repeat (VEC[i][0]) @(negedge clk);
            run_access(VEC[i][1], 1'b0, lat);
            check(lat >= 1 && lat <= VEC[i][2], "R10", "grant latency", lat, VEC[i][2]);
        end

        // R7, R8 long access defers refreshes, then backlog drains
        #1 r0 = ref_cnt;
        run_access(5 * N_INT, 1'b0, lat);
        #1;
        check(ref_cnt == r0, "R7", "refresh during access", ref_cnt - r0, 0);
        r0 = ref_cnt;
        repeat (6 * CBR_LEN + 6) @(negedge clk);
        #1;
        check(ref_cnt - r0 >= 4, "R8", "backlog drained after access", ref_cnt - r0, 5);

        // R9 continuous traffic: refresh held off until backlog is full
        run_access(12, 1'b1, lat);
        #1 r0 = ref_cnt;
        t0 = cyc;
        while (cyc - t0 < 6 * N_INT - 10) run_access(12, 1'b1, lat);
        #1;
        check(ref_cnt == r0, "R9", "refresh before backlog full", ref_cnt - r0, 0);
        while (cyc - t0 < 14 * N_INT) run_access(12, 1'b1, lat);
        #1;
        check(ref_cnt - r0 >= 3, "R9", "forced refresh at full backlog", ref_cnt - r0, 6);
        host_req = 1'b0;

        // R8 long-run count matches elapsed intervals
        repeat (10 * CBR_LEN + 20) @(negedge clk);
        #1;
        expv = (cyc - t_init) / N_INT;
        check(ref_cnt >= expv - 1 && ref_cnt <= expv, "R8",
              "total refreshes versus intervals", ref_cnt, expv);

        // R11 access longer than retention limit forces re-wake
        run_access(P_LIMIT / CLK_PERIOD + 100, 1'b0, lat);
        n = 0;
        while (init_done && n < 20) begin @(negedge clk); n++; end
        #1;
        check(init_done === 1'b0, "R11", "init_done falls after stale", init_done, 0);
        t_fall = cyc;
        n = 0;
        while (!init_done && n < 300) begin @(negedge clk); n++; end
        #1;
        check(wake_seen == WAKE_N, "R11", "re-wake cycles", wake_seen, WAKE_N);
        check(init_done === 1'b1 && cyc - t_fall <= WAKE_N * CBR_LEN + 10, "R11",
              "re-wake without pause", cyc - t_fall, WAKE_N * CBR_LEN + 3);
        repeat (5) @(negedge clk);

        // pin-level rules accumulated over the whole run
        check(r4_bad == 0, "R4", "CBR edge timing violations", r4_bad, 0);
        check(r5_bad == 0, "R5", "we_n low samples", r5_bad, 0);
        check(r7_bad == 0, "R7", "strobes active with grant or busy", r7_bad, 0);
        check(r10_bad == 0, "R10", "grant pulse or init violations", r10_bad, 0);

        // R1 reset in mid operation
        repeat (N_INT - 5) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check(ras_n === 1'b1 && lcas_n === 1'b1 && ucas_n === 1'b1, "R1",
              "strobes after mid reset", {ras_n, lcas_n, ucas_n}, 7);
        check(init_done === 1'b0 && host_grant === 1'b0, "R1",
              "status after mid reset", {init_done, host_grant}, 0);

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule